// File: doc/BRIEF.md
# Serial Port Interrupt and DMA Completion Controller

This block produces the one interrupt request of a serial port that carries two data channels, A (index 0) and B (index 1). Each channel reports a finished serial word with a one-cycle strobe. The controller turns those strobes into interrupt events, in one of two modes for each channel:

- **Single-word mode:** every completed word is an event.
- **DMA mode:** an event is raised only when the channel's word counter runs out. At that point the channel's DMA activity stops by itself.

When 16-to-32-bit packing is on, two serial words form one unit. Only the second half of each pair counts as a word.

Events from both channels reach a single sticky latch after a fixed two-clock delay. The latch is kept whether or not the request is masked. A per-channel source register shows which channel caused the latch to set. Software clears the latch and the source register together.

Top module: `sport_irq_ctl`

## Requirements
- R1: Channels A and B share one latch (`irq_latch`) and one request (`irq`); an event on either channel sets them.
- R2: A word strobe sampled at rising edge k that produces an event makes `irq_latch` read 1 after edge k+1, and not yet after edge k.
- R3: With `pack_en` = 1, only every second strobe of an enabled channel counts as a word; the first strobe is the low half and gives no event.
- R4: A channel with its `chan_en` bit at 0 ignores strobes and resets its half-word toggle, so the first strobe after re-enable is again a low half.
- R5: With the channel's `dma_sel` bit at 0, each counted word raises an event.
- R6: With `dma_sel` = 1, a count load of N > 0 sets `dma_busy`. Each counted word decrements the counter. The Nth word clears `dma_busy` after the edge that samples it and raises one event; earlier words raise none.
- R7: Loading a count of 0 leaves `dma_busy` at 0 and raises no event.
- R8: With `dma_sel` = 1 and `dma_busy` = 0, strobes raise no event.
- R9: When `irq_mask` = 1, `irq` stays 0 while `irq_latch` still sets. Unmasking after a clear gives `irq` = 0. Unmasking with the latch still set gives `irq` = 1.
- R10: Events from both channels in the same cycle set the latch once, and `src_stat` reads 2'b11. Bit 0 of `src_stat` is channel A and bit 1 is channel B.
- R11: A `latch_clr` pulse clears `irq_latch` and `src_stat`. An event reaching the latch on the same edge wins over the clear. Without a clear, the latch holds.
- R12: After synchronous reset, `irq`, `irq_latch`, `src_stat` and `dma_busy` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chan_en | input | NCH | Channel enable, one bit per channel |
| pack_en | input | 1 | 16-to-32-bit packing enable for the port |
| word_done | input | NCH | One-cycle strobe: last bit of a serial word shifted |
| dma_sel | input | NCH | 1 = channel runs in DMA mode |
| cnt_ld | input | NCH | Load strobe for the channel word counter |
| cnt_val | input | CNT_W | Word count applied on a load |
| irq_mask | input | 1 | 1 = request output masked |
| latch_clr | input | 1 | Clears latch and source status |
| irq | output | 1 | Interrupt request |
| irq_latch | output | 1 | Sticky interrupt latch |
| src_stat | output | NCH | Channel(s) that set the latch |
| dma_busy | output | NCH | DMA transfer in progress per channel |

## Verification
The inline assertions check several rules on every cycle:
- the two-clock delay between an event and the rise of the latch;
- the latch holding until a clear;
- the source status implying the latch;
- the packing rule that an event needs the high half;
- the silence of disabled channels;
- a busy channel always holding a nonzero count, and a zero load never starting DMA.

The bench's scenarios are what show the end-to-end behaviour. These are the per-mode sequences of strobes with the expected source bits, the counting down to a single final event, the toggle reset on disable, and the ordering of clear and unmask against the latch.

// File: rtl/sirq_pkg.sv
// Package for the serial-port interrupt controller.
// Holds the per-channel control bundle and the fixed event latency.
package sirq_pkg;

    // Clock edges from the strobe-sampling edge to the latch update (fixed by behaviour).
    localparam int IRQ_LAT = 2;

    // Per-channel control inputs gathered into one bundle.
    typedef struct packed {
        logic en;       // channel enabled
        logic pack;     // two halves form one counted word
        logic wd;       // word-complete strobe
        logic dma_sel;  // DMA mode select
        logic ld;       // counter load strobe
    } chan_ctl_t;

endpackage

// File: rtl/sirq_chan.sv
// One serial channel: half-word toggle, DMA word counter and event generation.
// Assumes word strobes last one cycle. The event is registered once (evt_d),
// forming the first stage of the two-clock latency to the shared latch.
module sirq_chan
    import sirq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  chan_ctl_t        ctl,
    input  logic [CNT_W-1:0] ld_val,
    output logic             busy,
    output logic             evt,
    output logic             evt_d
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic             half_q;
    logic [CNT_W-1:0] cnt_q;
    logic             unit;
    logic             dma_word;
    logic             last_word;

    // A counted word: full word unpacked, or the high half when packing.
    assign unit      = ctl.en && ctl.wd && (!ctl.pack || half_q);
    assign dma_word  = unit && ctl.dma_sel && busy && !ctl.ld;
    assign last_word = dma_word && (cnt_q == CNT_ONE);
    assign evt       = (unit && !ctl.dma_sel) || last_word;

    // Half-word toggle: cleared while disabled or unpacked, flips on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !ctl.en || !ctl.pack) begin
            half_q <= 1'b0;
        end else if (ctl.wd) begin
            half_q <= ~half_q;
        end
    end

    // DMA counter: load, count down per word, stop itself at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            busy  <= 1'b0;
        end else if (!ctl.dma_sel) begin
            busy  <= 1'b0;
        end else if (ctl.ld) begin
            cnt_q <= ld_val;
            busy  <= (ld_val != '0);
        end else if (dma_word) begin
            cnt_q <= cnt_q - CNT_ONE;
            if (cnt_q == CNT_ONE) begin
                busy <= 1'b0;
            end
        end
    end

    // First latency stage of the event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_d <= 1'b0;
        end else begin
            evt_d <= evt;
        end
    end

    assert_busy_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q != '0));

    assert_zero_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.dma_sel && ctl.ld && (ld_val == '0)) |=> !busy);

    assert_pack_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.pack && evt) |-> half_q);

    assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.en |-> !evt);

endmodule

// File: rtl/sirq_latch.sv
// Shared sticky interrupt latch with per-channel source status and output mask.
// Assumes set_vec is already delayed by one stage; a set on the same edge
// as a clear wins so no event is lost.
module sirq_latch #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] set_vec,
    input  logic           clr,
    input  logic           mask,
    output logic           latch,
    output logic [NCH-1:0] stat,
    output logic           irq
);

    // Latch and source bits: set by events, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch <= 1'b0;
            stat  <= '0;
        end else begin
            latch <= (|set_vec) | (latch & ~clr);
            stat  <= set_vec | (stat & {NCH{~clr}});
        end
    end

    assign irq = latch & ~mask;

    assert_latch_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (latch && !clr) |=> latch);

    assert_stat_needs_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|stat) |-> latch);

endmodule

// File: rtl/sport_irq_ctl.sv
// Serial-port interrupt and DMA completion controller (top).
// Instantiates one channel slice per data channel, then merges their delayed
// events into a single shared latch and request. Assumes one clock domain.
module sport_irq_ctl
    import sirq_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   chan_en,
    input  logic             pack_en,
    input  logic [NCH-1:0]   word_done,
    input  logic [NCH-1:0]   dma_sel,
    input  logic [NCH-1:0]   cnt_ld,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             irq_mask,
    input  logic             latch_clr,
    output logic             irq,
    output logic             irq_latch,
    output logic [NCH-1:0]   src_stat,
    output logic [NCH-1:0]   dma_busy
);

    logic [NCH-1:0] chan_evt;
    logic [NCH-1:0] evt_dly;

    // One slice per channel.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        chan_ctl_t ctl;
        assign ctl = '{en: chan_en[c], pack: pack_en, wd: word_done[c],
                       dma_sel: dma_sel[c], ld: cnt_ld[c]};
        sirq_chan #(.CNT_W(CNT_W)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .ctl    (ctl),
            .ld_val (cnt_val),
            .busy   (dma_busy[c]),
            .evt    (chan_evt[c]),
            .evt_d  (evt_dly[c])
        );
    end

    sirq_latch #(.NCH(NCH)) u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (evt_dly),
        .clr     (latch_clr),
        .mask    (irq_mask),
        .latch   (irq_latch),
        .stat    (src_stat),
        .irq     (irq)
    );

    assert_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_latch) |-> $past(|chan_evt, IRQ_LAT));

    assert_shared_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_dly) |=> irq_latch);

endmodule

// File: tb/sim_sport_irq_ctl.sv
module sim_sport_irq_ctl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] chan_en, word_done, dma_sel, cnt_ld;
    logic       pack_en, irq_mask, latch_clr;
    logic [7:0] cnt_val;
    logic       irq, irq_latch;
    logic [1:0] src_stat, dma_busy;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    sport_irq_ctl #(.NCH(2), .CNT_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .pack_en(pack_en),
        .word_done(word_done), .dma_sel(dma_sel), .cnt_ld(cnt_ld),
        .cnt_val(cnt_val), .irq_mask(irq_mask), .latch_clr(latch_clr),
        .irq(irq), .irq_latch(irq_latch), .src_stat(src_stat),
        .dma_busy(dma_busy)
    );

    // Vector fields: {chan_en[1:0], pack_en, word_done[1:0], expected src_stat[1:0]}
    localparam logic [6:0] VEC [0:10] = '{
        7'b11_0_01_01,  // R5 A single word
        7'b11_0_10_10,  // R1 B shares the latch
        7'b11_0_11_11,  // R10 both at once
        7'b11_1_01_00,  // R3 A low half
        7'b11_1_11_01,  // R3 A high, B low
        7'b11_1_10_10,  // R3 B high
        7'b01_1_11_00,  // R4 A low, B disabled
        7'b00_1_00_00,  // R4 disable all, toggle reset
        7'b11_1_01_00,  // R4 A low again after re-enable
        7'b11_1_01_01,  // R3 A high
        7'b11_0_01_01   // R5 unpacked again
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_latch();
        latch_clr = 1'b1;
        step();
        latch_clr = 1'b0;
    endtask

    // Pulse word strobes for one cycle, then wait one more edge for the latch.
    task automatic pulse(input logic [1:0] w);
        word_done = w;
        step();
        word_done = 2'b00;
        step();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; chan_en = 2'b00; word_done = 2'b00; dma_sel = 2'b00;
        cnt_ld = 2'b00; pack_en = 1'b0; irq_mask = 1'b0; latch_clr = 1'b0;
        cnt_val = 8'd0;
        @(negedge clk);
        step(); step();
        rst_n = 1'b1;
        step();

        // R12 reset state
        check({30'd0, irq, irq_latch}, 32'd0, "R12 irq/latch");
        check({30'd0, src_stat}, 32'd0, "R12 src_stat");
        check({30'd0, dma_busy}, 32'd0, "R12 dma_busy");

        // Vector table: non-DMA mode, unmasked
        for (int i = 0; i < 11; i++) begin
            chan_en = VEC[i][6:5];
            pack_en = VEC[i][4];
            pulse(VEC[i][3:2]);
            check({30'd0, src_stat}, {30'd0, VEC[i][1:0]}, $sformatf("R1/R3/R4/R5 vec%0d src_stat", i));
            check({31'd0, irq_latch}, {31'd0, |VEC[i][1:0]}, $sformatf("R1 vec%0d latch", i));
            check({31'd0, irq}, {31'd0, |VEC[i][1:0]}, $sformatf("R1 vec%0d irq", i));
            clear_latch();
        end
        chan_en = 2'b11;
        pack_en = 1'b0;

        // R2 latency: not after edge k, set after edge k+1
        word_done = 2'b01;
        step();
        word_done = 2'b00;
        check({31'd0, irq_latch}, 32'd0, "R2 latch after first edge");
        step();
        check({31'd0, irq_latch}, 32'd1, "R2 latch after second edge");
        clear_latch();
        check({31'd0, irq_latch}, 32'd0, "R11 cleared");

        // R6 DMA block of three words on channel A
        dma_sel = 2'b01;
        cnt_val = 8'd3;
        cnt_ld  = 2'b01;
        step();
        cnt_ld  = 2'b00;
        check({30'd0, dma_busy}, 32'd1, "R6 busy after load");
        pulse(2'b01);
        check({31'd0, irq_latch}, 32'd0, "R6 no event word 1");
        pulse(2'b01);
        check({31'd0, irq_latch}, 32'd0, "R6 no event word 2");
        word_done = 2'b01;
        step();
        word_done = 2'b00;
        check({30'd0, dma_busy}, 32'd0, "R6 busy cleared at last word");
        check({31'd0, irq_latch}, 32'd0, "R2 DMA latch not yet");
        step();
        check({31'd0, irq_latch}, 32'd1, "R6 block completion latch");
        check({30'd0, src_stat}, 32'd1, "R6 source A");
        clear_latch();

        // R8 DMA selected but idle: strobes ignored
        pulse(2'b01);
        check({31'd0, irq_latch}, 32'd0, "R8 idle DMA no event");
        check({30'd0, dma_busy}, 32'd0, "R8 still idle");

        // R7 zero count load
        cnt_val = 8'd0;
        cnt_ld  = 2'b01;
        step();
        cnt_ld  = 2'b00;
        check({30'd0, dma_busy}, 32'd0, "R7 zero load not busy");
        pulse(2'b01);
        step();
        check({31'd0, irq_latch}, 32'd0, "R7 no event");
        dma_sel = 2'b00;

        // R9 masking
        irq_mask = 1'b1;
        pulse(2'b10);
        check({31'd0, irq_latch}, 32'd1, "R9 masked latch set");
        check({31'd0, irq}, 32'd0, "R9 masked irq low");
        clear_latch();
        irq_mask = 1'b0;
        step();
        check({31'd0, irq}, 32'd0, "R9 unmask after clear");
        irq_mask = 1'b1;
        pulse(2'b10);
        irq_mask = 1'b0;
        step();
        check({31'd0, irq}, 32'd1, "R9 unmask with stale latch");
        clear_latch();

        // R11 set on the same edge as clear wins
        word_done = 2'b01;
        step();
        word_done = 2'b00;
        latch_clr = 1'b1;
        step();
        latch_clr = 1'b0;
        check({31'd0, irq_latch}, 32'd1, "R11 set beats clear");
        check({30'd0, src_stat}, 32'd1, "R11 status kept");
        step();
        check({31'd0, irq_latch}, 32'd1, "R11 latch holds");
        clear_latch();

        // R12 reset mid-run
        irq_mask = 1'b1;
        pulse(2'b01);
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        irq_mask = 1'b0;
        check({30'd0, irq, irq_latch}, 32'd0, "R12 reset clears latch");
        check({30'd0, src_stat}, 32'd0, "R12 reset clears status");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule